// File: doc/BRIEF.md
# Relative Countdown Alarm

This block is a wake-up timer that counts a relative interval down to zero and then raises a pending flag. Software writes the interval into a single register as four packed fields: days, hours, minutes and seconds. While the run bit is set, every pulse on the one-hertz tick enable removes one second from that count. The count behaves as a mixed-radix number: seconds borrow from minutes, minutes from hours, and hours from days.

When a tick takes the count from one second to zero, the pending flag is set and counting stops, because a zero count cannot go lower. The interrupt output is the pending flag gated by an interrupt-enable bit. Software clears the flag by writing one to its status bit. A small register bus (address, write strobe, write data and combinational read data) gives access to the interval, run, interrupt-enable and status registers. Reading the interval register returns the live remaining count.

Top module: `alarm_countdown`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: A write to offset 0x0C loads the interval, with seconds in bits 5:0, minutes in bits 13:8, hours in bits 20:16 and days in bits 28:21. Reading 0x0C returns the live count in the same layout, and all other bits read as zero.
- R3: While the run bit (bit 8 at offset 0x14) is set, each cycle with `tick_1hz` high removes one second from a nonzero count. Cycles without a tick leave the count unchanged.
- R4: A seconds field at zero wraps to 59 and borrows from minutes. Minutes wrap to 59 and borrow from hours. Hours wrap to 23 and borrow from days.
- R5: While the run bit is clear, ticks leave the count frozen and do not set the pending flag.
- R6: A tick that takes the count from 0d 00:00:01 to zero sets the pending flag (bit 0 at offset 0x1C). Further ticks leave the count at zero.
- R7: `irq` is high exactly when the pending flag is set and the interrupt-enable bit (bit 0 at offset 0x18) is set.
- R8: Writing 1 to status bit 0 clears the pending flag. Writing 0 there leaves it unchanged.
- R9: If an expiry and a clearing write fall in the same cycle, the expiry wins and the flag stays set.
- R10: An interval write reloads the count. If it coincides with a tick, the written value is kept undecremented and no expiry occurs.
- R11: With a zero interval, no tick sets the pending flag, whether the run bit is set or clear.
- R12: Writes to unmapped offsets change no register, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, one per second |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions treat `tick_1hz` as an arbitrary enable. They do not assume that ticks are spaced apart. Each property excludes the cycles that carry an interval write, because a load may legally change the count or suppress an expiry in any cycle. The stimulus changes the bus and the tick only on the falling clock edge. It issues one write per cycle and places ticks either on their own or deliberately in the same cycle as a reload or a status clear, so that the priority rules are exercised.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int NUM_FIELDS = 4;
    localparam int LANE_W     = 8;
    localparam int WORD_W     = 32;

    // lane 0 = seconds, 1 = minutes, 2 = hours, 3 = days
    localparam int FIELD_LSB  [NUM_FIELDS] = '{0, 8, 16, 21};
    localparam int FIELD_W    [NUM_FIELDS] = '{6, 6, 5, 8};
    localparam int FIELD_WRAP [NUM_FIELDS] = '{59, 59, 23, 255};

    localparam logic [7:0] OFS_INTERVAL = 8'h0C;
    localparam logic [7:0] OFS_RUN      = 8'h14;
    localparam logic [7:0] OFS_IRQ_EN   = 8'h18;
    localparam logic [7:0] OFS_STATUS   = 8'h1C;

    localparam int RUN_BIT    = 8;
    localparam int IRQ_EN_BIT = 0;
    localparam int PEND_BIT   = 0;

    typedef logic [LANE_W-1:0] lane_t;
    typedef lane_t [NUM_FIELDS-1:0] lanes_t;

    typedef struct packed {
        logic        load;
        lanes_t      load_val;
        logic        run;
        logic        irq_en;
        logic        clr_pend;
    } ctrl_t;

    function automatic lanes_t unpack_interval(input logic [WORD_W-1:0] w);
        lanes_t r;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            r[i] = '0;
            for (int b = 0; b < FIELD_W[i]; b++) begin
                r[i][b] = w[FIELD_LSB[i] + b];
            end
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] pack_interval(input lanes_t l);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            for (int b = 0; b < FIELD_W[i]; b++) begin
                w[FIELD_LSB[i] + b] = l[i][b];
            end
        end
        return w;
    endfunction

    function automatic logic lanes_is_zero(input lanes_t l);
        return (l == '0);
    endfunction

    function automatic logic lanes_is_one(input lanes_t l);
        lanes_t one;
        one    = '0;
        one[0] = lane_t'(1);
        return (l == one);
    endfunction

endpackage

// File: rtl/alarm_regbus.sv
module alarm_regbus
    import alarm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [WORD_W-1:0]   bus_wdata,
    input  lanes_t              count_q,
    input  logic                pend_q,
    output ctrl_t               ctrl,
    output logic [WORD_W-1:0]   bus_rdata
);

    logic run_q;
    logic irq_en_q;
    logic hit_interval;
    logic hit_run;
    logic hit_irq_en;
    logic hit_status;
    logic unused_wdata_bits;

    assign hit_interval = (bus_addr == ADDR_W'(OFS_INTERVAL));
    assign hit_run      = (bus_addr == ADDR_W'(OFS_RUN));
    assign hit_irq_en   = (bus_addr == ADDR_W'(OFS_IRQ_EN));
    assign hit_status   = (bus_addr == ADDR_W'(OFS_STATUS));

    assign unused_wdata_bits = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            irq_en_q <= 1'b0;
        end else if (bus_wr) begin
            if (hit_run) begin
                run_q <= bus_wdata[RUN_BIT];
            end
            if (hit_irq_en) begin
                irq_en_q <= bus_wdata[IRQ_EN_BIT];
            end
        end
    end

    always_comb begin
        ctrl.load     = bus_wr && hit_interval;
        ctrl.load_val = unpack_interval(bus_wdata);
        ctrl.run      = run_q;
        ctrl.irq_en   = irq_en_q;
        ctrl.clr_pend = bus_wr && hit_status && bus_wdata[PEND_BIT];
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_interval) begin
            bus_rdata = pack_interval(count_q);
        end else if (hit_run) begin
            bus_rdata[RUN_BIT] = run_q;
        end else if (hit_irq_en) begin
            bus_rdata[IRQ_EN_BIT] = irq_en_q;
        end else if (hit_status) begin
            bus_rdata[PEND_BIT] = pend_q;
        end
    end

endmodule

// File: rtl/alarm_dhms_counter.sv
module alarm_dhms_counter
    import alarm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  lanes_t load_val,
    input  logic   tick,
    input  logic   run,
    output lanes_t count_q,
    output logic   expire
);

    logic                  step;
    logic [NUM_FIELDS-1:0] borrow;
    lanes_t                count_dec;
    lanes_t                count_d;

    // a zero count never steps, so the day lane never wraps
    assign step      = tick && run && !load && !lanes_is_zero(count_q);
    assign borrow[0] = step;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_lane
        logic lane_zero;
        assign lane_zero = (count_q[i] == '0);

        always_comb begin
            if (!borrow[i]) begin
                count_dec[i] = count_q[i];
            end else if (lane_zero) begin
                count_dec[i] = lane_t'(FIELD_WRAP[i]);
            end else begin
                count_dec[i] = count_q[i] - lane_t'(1);
            end
        end

        if (i < NUM_FIELDS - 1) begin : g_chain
            assign borrow[i+1] = borrow[i] && lane_zero;
        end
    end

    assign count_d = load ? load_val : count_dec;
    assign expire  = step && lanes_is_one(count_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

endmodule

// File: rtl/alarm_pend_flag.sv
module alarm_pend_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    output logic pend_q,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (set) begin
            pend_q <= 1'b1;
        end else if (clr) begin
            pend_q <= 1'b0;
        end
    end

    assign irq = pend_q && irq_en;

endmodule

// File: rtl/alarm_countdown.sv
module alarm_countdown
    import alarm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    ctrl_t  ctrl;
    lanes_t count_q;
    logic   expire;
    logic   pend_q;

    alarm_regbus #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .count_q   (count_q),
        .pend_q    (pend_q),
        .ctrl      (ctrl),
        .bus_rdata (bus_rdata)
    );

    alarm_dhms_counter u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (ctrl.load),
        .load_val (ctrl.load_val),
        .tick     (tick_1hz),
        .run      (ctrl.run),
        .count_q  (count_q),
        .expire   (expire)
    );

    alarm_pend_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set    (expire),
        .clr    (ctrl.clr_pend),
        .irq_en (ctrl.irq_en),
        .pend_q (pend_q),
        .irq    (irq)
    );

endmodule

// File: rtl/alarm_countdown_chk.sv
module alarm_countdown_chk
    import alarm_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   tick_1hz,
    input ctrl_t  ctrl,
    input lanes_t count_q,
    input logic   pend_q,
    input logic   irq
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!pend_q && !ctrl.run && !ctrl.irq_en && lanes_is_zero(count_q)));

    p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !ctrl.load) |=> $stable(count_q));

    p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!tick_1hz && !ctrl.load) |=> $stable(count_q));

    p_zero_stays_r6: assert property (@(posedge clk) disable iff (rst)
        (lanes_is_zero(count_q) && !ctrl.load) |=> lanes_is_zero(count_q));

    p_expiry_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> ($past(tick_1hz) && $past(ctrl.run) && !$past(ctrl.load)
                           && lanes_is_one($past(count_q))));

    p_pend_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !ctrl.clr_pend) |=> pend_q);

    p_irq_needs_both_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (pend_q && ctrl.irq_en));

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (lanes_is_zero(count_q) && !pend_q && !ctrl.load) |=> !pend_q);

endmodule

bind alarm_countdown alarm_countdown_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_1hz (tick_1hz),
    .ctrl     (ctrl),
    .count_q  (count_q),
    .pend_q   (pend_q),
    .irq      (irq)
);

// File: tb/test_alarm_countdown.sv
`timescale 1ns/1ps
module test_alarm_countdown;

    localparam logic [7:0] A_IV  = 8'h0C;
    localparam logic [7:0] A_RUN = 8'h14;
    localparam logic [7:0] A_IE  = 8'h18;
    localparam logic [7:0] A_ST  = 8'h1C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1hz = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    alarm_countdown i_alarm_countdown (
        .clk       (clk),
        .rst       (rst),
        .tick_1hz  (tick_1hz),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic logic [31:0] iv(int d, int h, int m, int s);
        return (32'(d) << 21) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
    endfunction

    task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic write_and_tick(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick_1hz = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; tick_1hz = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_1hz = 1'b1;
            @(negedge clk); tick_1hz = 1'b0;
        end
    endtask

    task automatic check_reg(string req, logic [7:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        check_eq(req, bus_rdata, exp);
    endtask

    task automatic check_irq(string req, logic exp);
        #1;
        check_eq(req, 32'(irq), 32'(exp));
    endtask

    task automatic t_reset_r1();
        check_reg("R1", A_IV, 0);
        check_reg("R1", A_RUN, 0);
        check_reg("R1", A_IE, 0);
        check_reg("R1", A_ST, 0);
        check_irq("R1", 1'b0);
    endtask

    task automatic t_layout_r2();
        bus_write(A_IV, iv(200, 17, 42, 33));
        check_reg("R2", A_IV, iv(200, 17, 42, 33));
        bus_write(A_IV, iv(5, 3, 2, 1) | 32'hE000_C0C0);
        check_reg("R2", A_IV, iv(5, 3, 2, 1));
    endtask

    task automatic t_count_r3();
        bus_write(A_IV, iv(0, 0, 5, 10));
        bus_write(A_RUN, 32'h100);
        check_reg("R3", A_RUN, 32'h100);
        ticks(3);
        check_reg("R3", A_IV, iv(0, 0, 5, 7));
        repeat (10) @(negedge clk);
        check_reg("R3", A_IV, iv(0, 0, 5, 7));
    endtask

    task automatic t_borrow_r4();
        bus_write(A_IV, iv(1, 0, 0, 0));
        ticks(1);
        check_reg("R4", A_IV, iv(0, 23, 59, 59));
        bus_write(A_IV, iv(0, 2, 0, 0));
        ticks(1);
        check_reg("R4", A_IV, iv(0, 1, 59, 59));
        bus_write(A_IV, iv(3, 4, 1, 0));
        ticks(1);
        check_reg("R4", A_IV, iv(3, 4, 0, 59));
    endtask

    task automatic t_freeze_r5();
        bus_write(A_IV, iv(0, 0, 0, 1));
        bus_write(A_RUN, 32'h0);
        ticks(5);
        check_reg("R5", A_IV, iv(0, 0, 0, 1));
        check_reg("R5", A_ST, 0);
    endtask

    task automatic t_expire_r6();
        bus_write(A_IV, iv(0, 0, 0, 2));
        bus_write(A_RUN, 32'h100);
        ticks(1);
        check_reg("R6", A_ST, 0);
        ticks(1);
        check_reg("R6", A_IV, 0);
        check_reg("R6", A_ST, 1);
        check_irq("R7", 1'b0);
        ticks(3);
        check_reg("R6", A_IV, 0);
        check_reg("R6", A_ST, 1);
    endtask

    task automatic t_irq_r7();
        bus_write(A_IE, 32'h1);
        check_irq("R7", 1'b1);
        bus_write(A_IE, 32'h0);
        check_irq("R7", 1'b0);
        bus_write(A_IE, 32'h1);
        check_reg("R7", A_IE, 1);
        check_irq("R7", 1'b1);
    endtask

    task automatic t_w1c_r8();
        bus_write(A_ST, 32'h0);
        check_reg("R8", A_ST, 1);
        check_irq("R8", 1'b1);
        bus_write(A_ST, 32'h1);
        check_reg("R8", A_ST, 0);
        check_irq("R8", 1'b0);
    endtask

    task automatic t_set_wins_r9();
        bus_write(A_IV, iv(0, 0, 0, 1));
        write_and_tick(A_ST, 32'h1);
        check_reg("R9", A_ST, 1);
        check_irq("R9", 1'b1);
        bus_write(A_ST, 32'h1);
        check_reg("R9", A_ST, 0);
    endtask

    task automatic t_reload_r10();
        bus_write(A_IV, iv(0, 0, 1, 0));
        ticks(1);
        check_reg("R10", A_IV, iv(0, 0, 0, 59));
        bus_write(A_IV, iv(0, 0, 0, 10));
        check_reg("R10", A_IV, iv(0, 0, 0, 10));
        bus_write(A_IV, iv(0, 0, 0, 1));
        write_and_tick(A_IV, iv(0, 0, 0, 30));
        check_reg("R10", A_IV, iv(0, 0, 0, 30));
        check_reg("R10", A_ST, 0);
    endtask

    task automatic t_idle_r11();
        bus_write(A_RUN, 32'h0);
        bus_write(A_IE, 32'h0);
        bus_write(A_IV, 32'h0);
        ticks(3);
        check_reg("R11", A_ST, 0);
        check_irq("R11", 1'b0);
        bus_write(A_RUN, 32'h100);
        ticks(3);
        check_reg("R11", A_IV, 0);
        check_reg("R11", A_ST, 0);
    endtask

    task automatic t_unmapped_r12();
        bus_write(A_IV, iv(9, 8, 7, 6));
        bus_write(A_RUN, 32'h0);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h04, 32'hFFFF_FFFF);
        check_reg("R12", 8'h10, 0);
        check_reg("R12", 8'h04, 0);
        check_reg("R12", A_IV, iv(9, 8, 7, 6));
        check_reg("R12", A_RUN, 0);
        check_reg("R12", A_IE, 0);
        check_reg("R12", A_ST, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_r1();
        t_layout_r2();
        t_count_r3();
        t_borrow_r4();
        t_freeze_r5();
        t_expire_r6();
        t_irq_r7();
        t_w1c_r8();
        t_set_wins_r9();
        t_reload_r10();
        t_idle_r11();
        t_unmapped_r12();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule